// File: doc/BRIEF.md
# Branch and Condition-Code Unit

This block executes the control-flow and flag-manipulation slice of a 16-bit instruction set. Each accepted instruction word comes with the program counter (already advanced past the word), the current N, Z, V and C flags and the value of the general register that a loop instruction names. The block returns one result record per instruction. The record holds whether control transfers, the next PC, the new flag nibble, an optional register write-back and a flag for words outside its three instruction classes.

The three classes are conditional branches with a signed 8-bit word offset, flag set and clear operations driven by a 4-bit mask, and a count-down loop instruction. The loop instruction decrements a register and jumps backwards by an unsigned 6-bit word distance while the result is nonzero. Results leave through a single output register, so the pipeline takes one instruction per cycle.

The input and output are valid/ready streams. A word is accepted on a cycle where `in_valid` and `in_ready` are both high. A result is consumed on a cycle where `out_valid` and `out_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so back-pressure on the output stalls the input with no extra buffering. While `out_valid` is high and `out_ready` is low, the result record holds steady.

Top module: `branch_cc_unit`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `out_valid` is low.
- R2: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, every result output keeps its value on the next cycle.
- R3: Words whose high byte is 0x01 to 0x07 are branches with these conditions. 0x01 is always taken. 0x02 is taken when Z is 0, and 0x03 when Z is 1. 0x04 is taken when N equals V, and 0x05 when N differs from V. 0x06 is taken when Z is 0 and N equals V. 0x07 is taken when Z is 1 or N differs from V. The flag nibble is {N,Z,V,C} in bits 3 to 0.
- R4: Words whose high byte is 0x80 to 0x87 are branches with these conditions. 0x80 is taken when N is 0, and 0x81 when N is 1. 0x82 is taken when C and Z are both 0. 0x83 is taken when C or Z is 1. 0x84 is taken when V is 0, and 0x85 when V is 1. 0x86 is taken when C is 0, and 0x87 when C is 1.
- R5: A taken branch gives target = PC + 2 × (bits 7:0 read as a signed byte), modulo 2^16. A branch that is not taken gives target = PC. A branch of either kind leaves the flags unchanged and does not write back.
- R6: A word of the form 0x00A0 | m clears each flag whose bit is set in the mask m (bits 3:0). It is not taken, gives target = PC and does not write back.
- R7: A word of the form 0x00B0 | m sets each flag whose bit is set in m. A mask of zero leaves the flags unchanged for both the set and the clear form.
- R8: A word with bits 15:9 equal to 0111111 is the loop instruction. It writes back register index bits 8:6 with the register value minus one, modulo 2^16, and it leaves the flags unchanged.
- R9: The loop instruction is taken when the decremented value is nonzero, with target = PC − 2 × bits 5:0 (unsigned). When the decremented value is zero, it is not taken and gives target = PC.
- R10: Any other word raises `out_illegal`. It gives taken 0, target = PC, unchanged flags and no write-back. Whenever write-back is off, `out_wb_reg` and `out_wb_val` are zero.
- R11: A word accepted on one clock edge has its result on the outputs, with `out_valid` high, right after that edge. Back-to-back words are accepted on consecutive cycles when `out_ready` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Unit can take a word this cycle |
| in_instr | input | 16 | Instruction word |
| in_pc | input | DW | PC advanced past the instruction |
| in_flags | input | 4 | Current {N,Z,V,C} |
| in_reg_val | input | DW | Value of the register named by the loop instruction |
| out_valid | output | 1 | Result record present |
| out_ready | input | 1 | Consumer takes the result |
| out_taken | output | 1 | Control transfers to the target |
| out_target | output | DW | Next PC |
| out_flags | output | 4 | New {N,Z,V,C} |
| out_wb_en | output | 1 | Register write-back requested |
| out_wb_reg | output | 3 | Write-back register index |
| out_wb_val | output | DW | Write-back value |
| out_illegal | output | 1 | Word not handled by this unit |

## Verification
The bound checker checks the following on every cycle:
- the reset state and the ready rule;
- that a stalled result holds steady;
- that an accepted word always yields a result on the next cycle;
- the flag arithmetic of the set and clear forms;
- the loop instruction's decrement and its taken/zero relation;
- that a word marked not handled never transfers control or writes back.

The per-opcode branch conditions across all sixteen flag combinations, the sign extension of the offset at its extremes, the wrap of a loop register from zero, and the ordering of results under random back-pressure are shown only by the bench's scenarios, which compare each consumed record against the reference model.

// File: rtl/bcu_pkg.sv
package bcu_pkg;
  localparam int FLAG_W  = 4;
  localparam int RIDX_W  = 3;
  localparam int INSTR_W = 16;
  localparam int BOFF_W  = 8;
  localparam int LOOP_W  = 6;
  localparam int SEL_W   = 4;

  // flag nibble bit positions
  localparam int F_N = 3;
  localparam int F_Z = 2;
  localparam int F_V = 1;
  localparam int F_C = 0;

  // top 12 bits of the flag operation words
  localparam logic [11:0] CC_CLR_HI = 12'h00A;
  localparam logic [11:0] CC_SET_HI = 12'h00B;
  // top 7 bits of the loop word
  localparam logic [6:0]  LOOP_HI   = 7'b0111111;

  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_BR   = 2'd1,
    KIND_CC   = 2'd2,
    KIND_LOOP = 2'd3
  } kind_e;
endpackage

// File: rtl/bcu_decode.sv
module bcu_decode
  import bcu_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output kind_e              kind,
  output logic [SEL_W-1:0]   cond_sel,
  output logic               cc_set,
  output logic [FLAG_W-1:0]  cc_mask,
  output logic [BOFF_W-1:0]  br_off,
  output logic [LOOP_W-1:0]  loop_dist,
  output logic [RIDX_W-1:0]  loop_reg
);
  logic lo_group, hi_group;

  // branch groups: high byte 0x01..0x07 and 0x80..0x87
  assign lo_group = (instr[15:11] == 5'b00000) && (instr[10:8] != 3'b000);
  assign hi_group = (instr[15:11] == 5'b10000);

  assign cond_sel  = {instr[15], instr[10:8]};
  assign cc_set    = instr[4];
  assign cc_mask   = instr[FLAG_W-1:0];
  assign br_off    = instr[BOFF_W-1:0];
  assign loop_dist = instr[LOOP_W-1:0];
  assign loop_reg  = instr[8:6];

  always_comb begin
    if (lo_group || hi_group)
      kind = KIND_BR;
    else if (instr[15:4] == CC_CLR_HI || instr[15:4] == CC_SET_HI)
      kind = KIND_CC;
    else if (instr[15:9] == LOOP_HI)
      kind = KIND_LOOP;
    else
      kind = KIND_NONE;
  end
endmodule

// File: rtl/bcu_cond.sv
module bcu_cond
  import bcu_pkg::*;
(
  input  logic [SEL_W-1:0]  sel,
  input  logic [FLAG_W-1:0] flags,
  output logic              take
);
  logic n, z, v, c, lt;

  assign n  = flags[F_N];
  assign z  = flags[F_Z];
  assign v  = flags[F_V];
  assign c  = flags[F_C];
  assign lt = n ^ v;

  always_comb begin
    unique case (sel)
      4'h1: take = 1'b1;
      4'h2: take = !z;
      4'h3: take = z;
      4'h4: take = !lt;
      4'h5: take = lt;
      4'h6: take = !z && !lt;
      4'h7: take = z || lt;
      4'h8: take = !n;
      4'h9: take = n;
      4'hA: take = !c && !z;
      4'hB: take = c || z;
      4'hC: take = !v;
      4'hD: take = v;
      4'hE: take = !c;
      4'hF: take = c;
      default: take = 1'b0;
    endcase
  end
endmodule

// File: rtl/bcu_target.sv
module bcu_target
  import bcu_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0]     pc,
  input  logic [BOFF_W-1:0] br_off,
  input  logic [LOOP_W-1:0] loop_dist,
  output logic [DW-1:0]     fwd_tgt,
  output logic [DW-1:0]     back_tgt
);
  localparam int BPAD = DW - BOFF_W - 1;
  localparam int LPAD = DW - LOOP_W - 1;

  logic [DW-1:0] br_bytes, loop_bytes;

  assign br_bytes   = {{BPAD{br_off[BOFF_W-1]}}, br_off, 1'b0};
  assign loop_bytes = {{LPAD{1'b0}}, loop_dist, 1'b0};
  assign fwd_tgt    = pc + br_bytes;
  assign back_tgt   = pc - loop_bytes;
endmodule

// File: rtl/branch_cc_unit.sv
module branch_cc_unit
  import bcu_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [INSTR_W-1:0]  in_instr,
  input  logic [DW-1:0]       in_pc,
  input  logic [FLAG_W-1:0]   in_flags,
  input  logic [DW-1:0]       in_reg_val,
  output logic                out_valid,
  input  logic                out_ready,
  output logic                out_taken,
  output logic [DW-1:0]       out_target,
  output logic [FLAG_W-1:0]   out_flags,
  output logic                out_wb_en,
  output logic [RIDX_W-1:0]   out_wb_reg,
  output logic [DW-1:0]       out_wb_val,
  output logic                out_illegal
);
  kind_e              kind;
  logic [SEL_W-1:0]   cond_sel;
  logic               cc_set;
  logic [FLAG_W-1:0]  cc_mask;
  logic [BOFF_W-1:0]  br_off;
  logic [LOOP_W-1:0]  loop_dist;
  logic [RIDX_W-1:0]  loop_reg;
  logic               br_take;
  logic [DW-1:0]      fwd_tgt, back_tgt, dec_val;

  logic               n_taken, n_wb_en, n_illegal;
  logic [DW-1:0]      n_target, n_wb_val;
  logic [FLAG_W-1:0]  n_flags;
  logic [RIDX_W-1:0]  n_wb_reg;
  logic               accept;

  bcu_decode u_dec (
    .instr    (in_instr),
    .kind     (kind),
    .cond_sel (cond_sel),
    .cc_set   (cc_set),
    .cc_mask  (cc_mask),
    .br_off   (br_off),
    .loop_dist(loop_dist),
    .loop_reg (loop_reg)
  );

  bcu_cond u_cond (
    .sel  (cond_sel),
    .flags(in_flags),
    .take (br_take)
  );

  bcu_target #(.DW(DW)) u_tgt (
    .pc       (in_pc),
    .br_off   (br_off),
    .loop_dist(loop_dist),
    .fwd_tgt  (fwd_tgt),
    .back_tgt (back_tgt)
  );

  assign dec_val = in_reg_val - {{(DW-1){1'b0}}, 1'b1};

  always_comb begin
    n_taken   = 1'b0;
    n_target  = in_pc;
    n_flags   = in_flags;
    n_wb_en   = 1'b0;
    n_wb_reg  = '0;
    n_wb_val  = '0;
    n_illegal = 1'b0;
    unique case (kind)
      KIND_BR: begin
        n_taken  = br_take;
        n_target = br_take ? fwd_tgt : in_pc;
      end
      KIND_CC: begin
        n_flags = cc_set ? (in_flags | cc_mask) : (in_flags & ~cc_mask);
      end
      KIND_LOOP: begin
        n_wb_en  = 1'b1;
        n_wb_reg = loop_reg;
        n_wb_val = dec_val;
        n_taken  = (dec_val != '0);
        n_target = (dec_val != '0) ? back_tgt : in_pc;
      end
      default: n_illegal = 1'b1;
    endcase
  end

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_taken   <= 1'b0;
      out_target  <= '0;
      out_flags   <= '0;
      out_wb_en   <= 1'b0;
      out_wb_reg  <= '0;
      out_wb_val  <= '0;
      out_illegal <= 1'b0;
    end else if (accept) begin
      out_valid   <= 1'b1;
      out_taken   <= n_taken;
      out_target  <= n_target;
      out_flags   <= n_flags;
      out_wb_en   <= n_wb_en;
      out_wb_reg  <= n_wb_reg;
      out_wb_val  <= n_wb_val;
      out_illegal <= n_illegal;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end
endmodule

// File: rtl/branch_cc_unit_chk.sv
module branch_cc_unit_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [15:0]   in_instr,
  input logic [DW-1:0] in_pc,
  input logic [3:0]    in_flags,
  input logic [DW-1:0] in_reg_val,
  input logic          out_valid,
  input logic          out_ready,
  input logic          out_taken,
  input logic [DW-1:0] out_target,
  input logic [3:0]    out_flags,
  input logic          out_wb_en,
  input logic [2:0]    out_wb_reg,
  input logic [DW-1:0] out_wb_val,
  input logic          out_illegal
);
  logic fire;
  assign fire = in_valid && in_ready;

  // R1
  reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);

  // R2
  ready_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == (!out_valid || out_ready));

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_target) &&
      $stable(out_flags) && $stable(out_taken) && $stable(out_wb_val) &&
      $stable(out_illegal)));

  // R11
  one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid);

  // R6
  cc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_instr[15:4] == 12'h00A) |=>
      (out_flags == ($past(in_flags) & ~$past(in_instr[3:0])) && !out_taken));

  // R7
  cc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_instr[15:4] == 12'h00B) |=>
      (out_flags == ($past(in_flags) | $past(in_instr[3:0])) && !out_taken));

  // R8
  loop_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_instr[15:9] == 7'b0111111) |=>
      (out_wb_en && out_wb_val == $past(in_reg_val) - 1'b1 &&
       out_wb_reg == $past(in_instr[8:6]) && out_flags == $past(in_flags)));

  // R9
  loop_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_wb_en) |-> (out_taken == (out_wb_val != '0)));

  // R10
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> (!out_taken && !out_wb_en &&
      out_wb_val == '0 && out_wb_reg == '0));
endmodule

bind branch_cc_unit branch_cc_unit_chk #(.DW(DW)) u_chk (.*);

// File: tb/branch_cc_unit_tb.sv
module branch_cc_unit_tb;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [15:0]   in_instr = '0;
  logic [DW-1:0] in_pc = '0;
  logic [3:0]    in_flags = '0;
  logic [DW-1:0] in_reg_val = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic          out_taken;
  logic [DW-1:0] out_target;
  logic [3:0]    out_flags;
  logic          out_wb_en;
  logic [2:0]    out_wb_reg;
  logic [DW-1:0] out_wb_val;
  logic          out_illegal;

  int checks = 0;
  int fails  = 0;
  bit stall_mode = 1'b0;
  bit done = 1'b0;
  bit prev_fire = 1'b0;

  logic [41:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  branch_cc_unit #(.DW(DW)) u_dut (.*);

  function automatic logic [41:0] model(input logic [15:0] ins, input logic [15:0] pc,
                                        input logic [3:0] fl, input logic [15:0] rv);
    logic n, z, v, c, t, ill, we;
    logic [15:0] tgt, wv;
    logic [3:0] nf;
    logic [2:0] wr;
    logic [7:0] hb;
    int off;
    n = fl[3]; z = fl[2]; v = fl[1]; c = fl[0];
    hb = ins[15:8];
    t = 0; ill = 0; we = 0; tgt = pc; wv = 0; wr = 0; nf = fl;
    if ((hb >= 8'h01 && hb <= 8'h07) || (hb >= 8'h80 && hb <= 8'h87)) begin
      case (hb)
        8'h01: t = 1;
        8'h02: t = !z;
        8'h03: t = z;
        8'h04: t = (n == v);
        8'h05: t = (n != v);
        8'h06: t = !z && (n == v);
        8'h07: t = z || (n != v);
        8'h80: t = !n;
        8'h81: t = n;
        8'h82: t = !c && !z;
        8'h83: t = c || z;
        8'h84: t = !v;
        8'h85: t = v;
        8'h86: t = !c;
        default: t = c;
      endcase
      off = ins[7] ? int'(ins[7:0]) - 256 : int'(ins[7:0]);
      if (t) tgt = 16'(int'(pc) + 2 * off);
    end else if (ins[15:4] == 12'h00A) begin
      nf = fl & ~ins[3:0];
    end else if (ins[15:4] == 12'h00B) begin
      nf = fl | ins[3:0];
    end else if (ins[15:9] == 7'b0111111) begin
      we = 1; wr = ins[8:6]; wv = rv - 16'd1;
      t = (wv != 0);
      if (t) tgt = 16'(int'(pc) - 2 * int'(ins[5:0]));
    end else begin
      ill = 1;
    end
    return {ill, t, tgt, nf, we, wr, wv};
  endfunction

  function automatic string tag_of(input logic [15:0] ins);
    if (ins[15:8] >= 8'h01 && ins[15:8] <= 8'h07) return "R3/R5";
    if (ins[15:8] >= 8'h80 && ins[15:8] <= 8'h87) return "R4/R5";
    if (ins[15:4] == 12'h00A) return "R6";
    if (ins[15:4] == 12'h00B) return "R7";
    if (ins[15:9] == 7'b0111111) return "R8/R9";
    return "R10";
  endfunction

  // monitor at the falling edge: inputs and outputs are settled
  always @(negedge clk) begin
    if (!rst_n) begin
      checks++;
      if (out_valid !== 1'b0) begin
        fails++;
        $display("FAIL R1 out_valid in reset got %b exp 0", out_valid);
      end
    end else begin
      checks++;
      if (in_ready !== (!out_valid || out_ready)) begin
        fails++;
        $display("FAIL R2 in_ready got %b exp %b", in_ready, !out_valid || out_ready);
      end
      if (prev_fire) begin
        checks++;
        if (out_valid !== 1'b1) begin
          fails++;
          $display("FAIL R11 out_valid after accept got %b exp 1", out_valid);
        end
      end
      if (out_valid && out_ready) begin
        logic [41:0] got;
        got = {out_illegal, out_taken, out_target, out_flags, out_wb_en, out_wb_reg, out_wb_val};
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R11 unexpected result got %h exp none", got);
        end else begin
          logic [41:0] e;
          string tg;
          e = exp_q.pop_front();
          tg = tag_q.pop_front();
          if (got !== e) begin
            fails++;
            $display("FAIL %s result got %h exp %h", tg, got, e);
          end
        end
      end
      prev_fire = in_valid && in_ready;
      if (in_valid && in_ready) begin
        exp_q.push_back(model(in_instr, in_pc, in_flags, in_reg_val));
        tag_q.push_back(tag_of(in_instr));
      end
    end
  end

  // consumer side: back-pressure in stall mode (R2)
  initial begin
    forever begin
      @(posedge clk);
      #1;
      out_ready = stall_mode ? (($urandom % 3) != 0) : 1'b1;
    end
  end

  task automatic send(input logic [15:0] ins, input logic [15:0] pc,
                      input logic [3:0] fl, input logic [15:0] rv);
    in_valid   = 1'b1;
    in_instr   = ins;
    in_pc      = pc;
    in_flags   = fl;
    in_reg_val = rv;
    do @(negedge clk); while (!in_ready);
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(posedge clk);
    #1;

    // R3 R4 R5: every branch opcode under all flag values, both offset signs
    for (int hb = 0; hb < 16; hb++) begin
      logic [7:0] op;
      if (hb == 0) continue;
      op = (hb < 8) ? 8'(hb) : 8'(8'h80 + hb - 8);
      for (int f = 0; f < 16; f++) begin
        send({op, 8'h7F}, 16'h1000, 4'(f), 16'h0);
        send({op, 8'h80}, 16'h0100, 4'(f), 16'h0);
      end
    end
    send(16'h0100, 16'h0002, 4'h0, 16'h0);  // R5 zero offset
    send(16'h01FF, 16'h0000, 4'h0, 16'h0);  // R5 wrap below zero
    idle(2);

    // R6 R7: all masks, including zero
    for (int m = 0; m < 16; m++) begin
      send(16'h00A0 | 16'(m), 16'h2000, 4'hF, 16'h0);
      send(16'h00B0 | 16'(m), 16'h2000, 4'h0, 16'h0);
      send(16'h00A0 | 16'(m), 16'h2000, 4'(m ^ 5), 16'h0);
    end
    idle(1);

    // R8 R9: loop word corners
    send(16'o077100, 16'h3000, 4'h6, 16'h0001); // decrements to zero
    send(16'o077277, 16'h3000, 4'h9, 16'h0000); // wraps to FFFF, far back
    send(16'o077705, 16'h3000, 4'h3, 16'h0005);
    send(16'o077000, 16'h3000, 4'h0, 16'h0002); // zero distance
    send(16'o077577, 16'h0010, 4'hF, 16'h8000); // target wraps

    // R10: words outside the handled encodings
    send(16'h0000, 16'h4000, 4'hA, 16'h1234);
    send(16'h00C5, 16'h4000, 4'h5, 16'h1234);
    send(16'h0090, 16'h4000, 4'h5, 16'h1234);
    send(16'h0800, 16'h4000, 4'hC, 16'h1234);
    send(16'h8800, 16'h4000, 4'h3, 16'h1234);
    send(16'o076777, 16'h4000, 4'h1, 16'h1234);
    send(16'hFFFF, 16'h4000, 4'hE, 16'h1234);
    idle(2);

    // R2 R11: random words under random back-pressure and gaps
    stall_mode = 1'b1;
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] w;
      case ($urandom % 5)
        0: w = {8'($urandom % 8), 8'($urandom)};
        1: w = {8'h80 | 8'($urandom % 8), 8'($urandom)};
        2: w = 16'h00A0 | 16'($urandom % 32);
        3: w = {7'b0111111, 9'($urandom)};
        default: w = 16'($urandom);
      endcase
      send(w, 16'($urandom), 4'($urandom), 16'($urandom % 4));
      if (($urandom % 4) == 0) idle(1);
    end
    stall_mode = 1'b0;
    idle(4);

    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R11 results left over got %0d exp 0", exp_q.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired got hang exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule